// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block sits between a console's CPU and PPU buses and the external memories of a game cartridge. It turns 16-bit CPU addresses into program ROM and program RAM addresses, and 14-bit PPU addresses into character memory addresses. Software programs it through a narrow serial port. Each CPU write at 0x8000 or above shifts one data bit into a five-bit accumulator. On the fifth write, the accumulated value lands in one of four configuration registers: control, character bank A, character bank B or program bank.

Every address output and strobe is registered, so a translation appears one clock after the request. The ROM sizes come in as parameters, as does whether character memory is writable RAM. These are powers-of-two bank counts that the surrounding system takes from the cartridge header. Program bank bit 4 gives large program ROMs a second level of banking: it pins the mapping to one 256 KB half, and bit 3 names that half.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write at 0x8000 or above whose data bit 7 is 1 empties the serial accumulator and its bit count and sets control bits 3:2 to 11. Control bits 4 and 1:0 and the three bank registers keep their values.
- R2: Any other CPU write at 0x8000 or above shifts data bit 0 in, first bit as the LSB. The fifth such write commits the five bits to the register chosen by CPU address bits 14:13 (00 control, 01 character bank A, 10 character bank B, 11 program bank). Writes one to four change no register.
- R3: After reset, control is 0x0C (program mode 3, character mode 0, mirroring 0) and all bank registers are 0.
- R4: Program modes 0 and 1 map 32 KB. The 16 KB bank is the program bank with bit 0 replaced by CPU address bit 14.
- R5: Program mode 2 maps 0x8000–0xBFFF to 16 KB bank 0, and 0xC000–0xFFFF to the bank in program bank bits 3:0.
- R6: Program mode 3 maps 0x8000–0xBFFF to the bank in program bank bits 3:0, and 0xC000–0xFFFF to the last 16 KB bank.
- R7: With program bank bit 4 set and more than eight 16 KB banks, bank numbers are taken modulo half the ROM and placed in the half named by program bank bit 3. The fixed bank of mode 3 becomes the last bank of that half.
- R8: Character mode (control bit 4) 0 maps one 8 KB bank, numbered character bank A shifted right by one. Mode 1 maps bank A at 0x0000–0x0FFF and bank B at 0x1000–0x1FFF, both in 4 KB units.
- R9: The mirroring output equals control bits 1:0: 0 one-screen low, 1 one-screen high, 2 vertical, 3 horizontal.
- R10: One clock after a CPU access, these outputs are valid:
  - The RAM select is high for 0x6000–0x7FFF, with RAM address equal to CPU address bits 12:0. The RAM write enable is high for writes in that window.
  - The ROM read strobe is high for reads at 0x8000 and above.
  - The pass-through flag is high for accesses below 0x6000.
- R11: One clock after a PPU write, the character write enable is high only when character memory is RAM and the PPU address is below 0x2000.
- R12: Every bank number is reduced modulo the configured bank count, so no output addresses past the end of a memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| prg_rom_addr | output | 14+PRG_BANK_BITS | Program ROM byte address |
| prg_rom_re | output | 1 | Program ROM read strobe |
| prg_ram_addr | output | 13 | Program RAM byte address |
| prg_ram_sel | output | 1 | Program RAM select |
| prg_ram_we | output | 1 | Program RAM write enable |
| cpu_pass | output | 1 | Access below the cartridge windows |
| ppu_addr | input | 14 | PPU address |
| ppu_wr | input | 1 | PPU write strobe |
| chr_addr | output | 12+CHR_BANK_BITS | Character memory byte address |
| chr_ram_we | output | 1 | Character RAM write enable |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The hardest state to reach from the ports is a clear that arrives partway through a serial load. Only a sequence of writes can put the accumulator there, and the accumulator is not visible. The stimulus first loads the control register with a non-default mode and mirroring value. It then shifts in two bits aimed at the program bank and sends a clear. Next comes a complete load of character bank A. The bench then probes both address spaces. A count that was not cleared would commit early to the wrong register, and this shows up as a wrong program or character address.

The outer-half override needs a program bank with bit 4 set on a ROM of more than eight banks. For this, a second instance with an eight-bank ROM and read-only character memory receives the same stimulus, which shows the override and the write enable staying off there.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int LOAD_LEN = 5;
  localparam int CNT_W    = $clog2(LOAD_LEN);
  localparam logic [LOAD_LEN-1:0] CTRL_RESET = 5'h0C;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORIZ  = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHRA = 2'd1,
    SEL_CHRB = 2'd2,
    SEL_PRG  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [LOAD_LEN-1:0] ctrl;
    logic [LOAD_LEN-1:0] chr_a;
    logic [LOAD_LEN-1:0] chr_b;
    logic [LOAD_LEN-1:0] prg;
  } bank_regs_t;
endpackage

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_data,
  output bank_regs_t regs
);
  logic [LOAD_LEN-2:0] shift_q;
  logic [CNT_W-1:0]    cnt_q;
  bank_regs_t          regs_q;
  logic                last_bit;
  logic [LOAD_LEN-1:0] commit_val;
  reg_sel_e            sel;

  assign last_bit   = (cnt_q == CNT_W'(LOAD_LEN - 1));
  assign commit_val = {cfg_data[0], shift_q};
  assign sel        = reg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q      <= '0;
      cnt_q        <= '0;
      regs_q.ctrl  <= CTRL_RESET;
      regs_q.chr_a <= '0;
      regs_q.chr_b <= '0;
      regs_q.prg   <= '0;
    end else if (cfg_wr) begin
      if (cfg_data[7]) begin
        shift_q     <= '0;
        cnt_q       <= '0;
        regs_q.ctrl <= regs_q.ctrl | CTRL_RESET;
      end else if (last_bit) begin
        unique case (sel)
          SEL_CTRL: regs_q.ctrl  <= commit_val;
          SEL_CHRA: regs_q.chr_a <= commit_val;
          SEL_CHRB: regs_q.chr_b <= commit_val;
          SEL_PRG:  regs_q.prg   <= commit_val;
          default:  regs_q.prg   <= commit_val;
        endcase
        shift_q <= '0;
        cnt_q   <= '0;
      end else begin
        for (int i = 0; i < LOAD_LEN - 1; i++) begin
          if (cnt_q == CNT_W'(i)) shift_q[i] <= cfg_data[0];
        end
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign regs = regs_q;

  // R1: clear forces program mode 3 and restarts the count
  a_r1_clear_sets_mode: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_data[7]) |=> (regs_q.ctrl[3:2] == 2'b11) && (cnt_q == '0));

  // R1: clear leaves bank registers alone
  a_r1_clear_keeps_banks: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_data[7]) |=> $stable(regs_q.chr_a) && $stable(regs_q.chr_b) && $stable(regs_q.prg));

  // R2: partial loads never touch a register
  a_r2_partial_holds: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_data[7] && !last_bit) |=> $stable(regs_q));

  // R2: a commit restarts the count
  a_r2_commit_restarts: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_data[7] && last_bit) |=> (cnt_q == '0));
endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import mapper_pkg::*;
#(
  parameter int PB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  bank_regs_t    regs,
  output logic [13+PB:0] rom_addr,
  output logic          rom_re,
  output logic [12:0]   ram_addr,
  output logic          ram_sel,
  output logic          ram_we,
  output logic          pass
);
  localparam int AW = 14 + PB;
  localparam logic [31:0] HALF_MASK = (32'd1 << (PB - 1)) - 32'd1;

  logic [1:0]          mode;
  logic                hi_half;
  logic [LOAD_LEN-1:0] inner;
  logic                fixed_last;
  logic                outer_on;
  logic [31:0]         inner_w;
  logic [31:0]         half_base;
  logic [PB-1:0]       bank;
  logic                in_ram;
  logic                any_acc;

  assign mode    = regs.ctrl[3:2];
  assign hi_half = cpu_addr[14];

  always_comb begin
    fixed_last = 1'b0;
    inner      = '0;
    unique case (mode)
      2'd0, 2'd1: inner = {regs.prg[4:1], hi_half};
      2'd2:       inner = hi_half ? {1'b0, regs.prg[3:0]} : '0;
      default: begin
        inner      = {1'b0, regs.prg[3:0]};
        fixed_last = hi_half;
      end
    endcase
  end

  generate
    if (PB > 3) begin : g_outer
      assign outer_on = regs.prg[4];
    end else begin : g_flat
      assign outer_on = 1'b0;
    end
  endgenerate

  assign inner_w   = 32'(inner);
  assign half_base = 32'(regs.prg[3]) << (PB - 1);

  always_comb begin
    if (outer_on) begin
      bank = PB'(half_base | (fixed_last ? HALF_MASK : (inner_w & HALF_MASK)));
    end else begin
      bank = fixed_last ? '1 : PB'(inner_w);
    end
  end

  assign in_ram  = (cpu_addr[15:13] == 3'b011);
  assign any_acc = cpu_rd || cpu_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_re   <= 1'b0;
      ram_addr <= '0;
      ram_sel  <= 1'b0;
      ram_we   <= 1'b0;
      pass     <= 1'b0;
    end else begin
      rom_addr <= {bank, cpu_addr[13:0]};
      rom_re   <= cpu_rd && cpu_addr[15];
      ram_addr <= cpu_addr[12:0];
      ram_sel  <= any_acc && in_ram;
      ram_we   <= cpu_wr && in_ram;
      pass     <= any_acc && (cpu_addr < 16'h6000);
    end
  end

  // R6: without the outer half, the fixed window reads the very last bank
  a_r6_fixed_last: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:14] == 2'b11 && regs.ctrl[3:2] == 2'b11 && !regs.prg[4])
    |=> (&rom_addr[AW-1:14]));

  // R10: ROM reads are flagged one clock later
  a_r10_rom_strobe: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15]) |=> rom_re && !ram_sel && !pass);
endmodule

// File: rtl/chr_bank_xlate.sv
module chr_bank_xlate
  import mapper_pkg::*;
#(
  parameter int CB = 4,
  parameter bit CHR_IS_RAM = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [13:0]    ppu_addr,
  input  logic           ppu_wr,
  input  bank_regs_t     regs,
  output logic [11+CB:0] chr_addr,
  output logic           chr_we
);
  logic [31:0]   unit_w;
  logic [CB-1:0] bank4;

  always_comb begin
    if (!regs.ctrl[4]) begin
      unit_w = 32'({regs.chr_a[4:1], ppu_addr[12]});
    end else begin
      unit_w = 32'(ppu_addr[12] ? regs.chr_b : regs.chr_a);
    end
  end

  assign bank4 = CB'(unit_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      chr_we   <= 1'b0;
    end else begin
      chr_addr <= {bank4, ppu_addr[11:0]};
      chr_we   <= CHR_IS_RAM && ppu_wr && !ppu_addr[13];
    end
  end

  // R11: nothing above the pattern area is ever written
  a_r11_no_we_high: assert property (@(posedge clk) disable iff (rst)
    (ppu_wr && ppu_addr[13]) |=> !chr_we);

  // R8: in split mode the upper window follows bank B
  a_r8_split_upper: assert property (@(posedge clk) disable iff (rst)
    (regs.ctrl[4] && ppu_addr[12] && $stable(regs.chr_b))
    |=> (chr_addr[11+CB:12] == CB'(32'($past(regs.chr_b)))));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_BITS = 5,
  parameter int CHR_BANK_BITS = 4,
  parameter bit CHR_IS_RAM    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  input  logic                       cpu_wr,
  input  logic                       cpu_rd,
  output logic [13+PRG_BANK_BITS:0]  prg_rom_addr,
  output logic                       prg_rom_re,
  output logic [12:0]                prg_ram_addr,
  output logic                       prg_ram_sel,
  output logic                       prg_ram_we,
  output logic                       cpu_pass,
  input  logic [13:0]                ppu_addr,
  input  logic                       ppu_wr,
  output logic [11+CHR_BANK_BITS:0]  chr_addr,
  output logic                       chr_ram_we,
  output logic [1:0]                 mirror_mode
);
  bank_regs_t regs;
  mirror_e    mir;
  logic       cfg_wr;

  assign cfg_wr = cpu_wr && cpu_addr[15];

  serial_cfg_loader u_loader (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cpu_addr[14:13]),
    .cfg_data (cpu_wdata),
    .regs     (regs)
  );

  prg_bank_xlate #(.PB(PRG_BANK_BITS)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .regs     (regs),
    .rom_addr (prg_rom_addr),
    .rom_re   (prg_rom_re),
    .ram_addr (prg_ram_addr),
    .ram_sel  (prg_ram_sel),
    .ram_we   (prg_ram_we),
    .pass     (cpu_pass)
  );

  chr_bank_xlate #(.CB(CHR_BANK_BITS), .CHR_IS_RAM(CHR_IS_RAM)) u_chr (
    .clk      (clk),
    .rst      (rst),
    .ppu_addr (ppu_addr),
    .ppu_wr   (ppu_wr),
    .regs     (regs),
    .chr_addr (chr_addr),
    .chr_we   (chr_ram_we)
  );

  assign mir         = mirror_e'(regs.ctrl[1:0]);
  assign mirror_mode = mir;

  // R9: mirroring only moves on a control commit or a clear
  a_r9_mirror_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(mirror_mode));
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  localparam int PBB = 5, CBB = 4, PBS = 3, CBS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic ppu_wr = 1'b0;

  logic [13+PBB:0] rom_b;  logic [13+PBS:0] rom_s;
  logic [11+CBB:0] chr_b;  logic [11+CBS:0] chr_s;
  logic re_b, re_s, rsel_b, rsel_s, rwe_b, rwe_s, pass_b, pass_s, cwe_b, cwe_s;
  logic [12:0] raddr_b, raddr_s;
  logic [1:0] mir_b, mir_s;

  always #5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANK_BITS(PBB), .CHR_BANK_BITS(CBB), .CHR_IS_RAM(1'b1)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .prg_rom_addr(rom_b), .prg_rom_re(re_b), .prg_ram_addr(raddr_b),
    .prg_ram_sel(rsel_b), .prg_ram_we(rwe_b), .cpu_pass(pass_b), .ppu_addr(ppu_addr),
    .ppu_wr(ppu_wr), .chr_addr(chr_b), .chr_ram_we(cwe_b), .mirror_mode(mir_b));

  cart_bank_mapper #(.PRG_BANK_BITS(PBS), .CHR_BANK_BITS(CBS), .CHR_IS_RAM(1'b0)) uut_small (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .prg_rom_addr(rom_s), .prg_rom_re(re_s), .prg_ram_addr(raddr_s),
    .prg_ram_sel(rsel_s), .prg_ram_we(rwe_s), .cpu_pass(pass_s), .ppu_addr(ppu_addr),
    .ppu_wr(ppu_wr), .chr_addr(chr_s), .chr_ram_we(cwe_s), .mirror_mode(mir_s));

  typedef struct { int cyc; int kind; longint expv; string req; } item_t;
  item_t sb[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // shadow configuration kept from the requirements
  int s_ctrl = 'h0C, s_ca = 0, s_cb = 0, s_prg = 0;

  function automatic longint exp_prg(int a, int ctrl, int pb, int lg);
    int total, half, mode, inner, bank;
    bit hi, fixed, ov;
    total = 1 << lg; half = total / 2; mode = (ctrl >> 2) & 3; hi = a[14];
    fixed = 0;
    if (mode <= 1) inner = (pb & 'h1E) | int'(hi);
    else if (mode == 2) inner = hi ? (pb & 15) : 0;
    else begin inner = pb & 15; fixed = hi; end
    ov = pb[4] && total > 8;
    if (fixed) bank = ov ? (pb[3] * half + half - 1) : total - 1;
    else bank = ov ? (pb[3] * half + inner % half) : inner % total;
    return longint'(bank) * 16384 + (a & 'h3FFF);
  endfunction

  function automatic longint exp_chr(int a, int ctrl, int ca, int cb, int lg);
    int total;
    total = 1 << lg;
    if (!ctrl[4]) return longint'((ca >> 1) % (total / 2)) * 8192 + (a & 'h1FFF);
    return longint'((a[12] ? cb : ca) % total) * 4096 + (a & 'hFFF);
  endfunction

  task automatic push(int kind, longint e, string req);
    item_t it;
    it.cyc = cyc; it.kind = kind; it.expv = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drive(int ca, int cd, bit rd, bit wr, int pa, bit pw);
    @(negedge clk);
    cpu_addr = 16'(ca); cpu_wdata = 8'(cd); cpu_rd = rd; cpu_wr = wr;
    ppu_addr = 14'(pa); ppu_wr = pw;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_reg(int sel, int val);
    for (int i = 0; i < 5; i++) drive('h8000 | (sel << 13), (val >> i) & 1, 0, 1, 0, 0);
    idle();
    case (sel)
      0: s_ctrl = val & 'h1F;
      1: s_ca = val & 'h1F;
      2: s_cb = val & 'h1F;
      default: s_prg = val & 'h1F;
    endcase
  endtask

  task automatic probe_prg(int a, string req);
    drive(a, 0, 1, 0, 0, 0);
    push(0, exp_prg(a, s_ctrl, s_prg, PBB), req);
    push(1, exp_prg(a, s_ctrl, s_prg, PBS), req);
    push(9, 1, req);
  endtask

  task automatic probe_chr(int a, bit w, string req);
    drive(0, 0, 0, 0, a, w);
    push(2, exp_chr(a, s_ctrl, s_ca, s_cb, CBB), req);
    push(3, exp_chr(a, s_ctrl, s_ca, s_cb, CBS), req);
    push(5, longint'(w && a < 'h2000), "R11");
    push(6, 0, "R11");
  endtask

  task automatic probe_mir(string req);
    idle();
    push(4, s_ctrl & 3, req);
  endtask

  function automatic longint actual(int kind);
    case (kind)
      0: return longint'(rom_b);  1: return longint'(rom_s);
      2: return longint'(chr_b);  3: return longint'(chr_s);
      4: return longint'(mir_b);  5: return longint'(cwe_b);
      6: return longint'(cwe_s);  7: return longint'(rsel_b);
      8: return longint'(rwe_b);  9: return longint'(re_b);
      10: return longint'(pass_b); 11: return longint'(raddr_b);
      12: return longint'(mir_s);
      default: return -1;
    endcase
  endfunction

  // monitor: compares each item one clock after it was pushed
  always begin
    @(posedge clk);
    cyc++;
    #2;
    while (sb.size() > 0 && sb[0].cyc == cyc - 1) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (actual(it.kind) !== it.expv) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual 0x%0h expected 0x%0h", it.req, it.kind,
                 actual(it.kind), it.expv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int pbs[6];
    pbs = '{'h00, 'h05, 'h0E, 'h12, 'h1A, 'h1F};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    probe_mir("R3");
    push(12, 0, "R3");
    probe_prg('h8123, "R3");
    probe_prg('hC456, "R3");
    probe_chr('h1234, 0, "R3");
    idle();

    // R4 R5 R6 R7 R12: every program mode, with and without outer half
    for (int m = 0; m < 4; m++) begin
      load_reg(0, m << 2);
      foreach (pbs[k]) begin
        load_reg(3, pbs[k]);
        probe_prg('h8123, m < 2 ? "R4" : (m == 2 ? "R5" : "R6"));
        probe_prg('hC456, pbs[k] >= 'h10 ? "R7" : "R12");
      end
    end

    // R8 R12: both character modes
    for (int cm = 0; cm < 2; cm++) begin
      load_reg(0, cm << 4);
      load_reg(1, 'h03); load_reg(2, 'h1C);
      probe_chr('h0ABC, 0, "R8"); probe_chr('h1DEF, 0, "R8");
      load_reg(1, 'h1F); load_reg(2, 'h0A);
      probe_chr('h0ABC, 0, "R12"); probe_chr('h1DEF, 0, "R8");
    end

    // R9: each mirroring code
    for (int mc = 0; mc < 4; mc++) begin
      load_reg(0, mc);
      probe_mir("R9");
      push(12, mc, "R9");
    end

    // R1 R2: clear partway through a program-bank load
    load_reg(3, 'h00);
    load_reg(0, 'h02);
    drive('hE000, 1, 0, 1, 0, 0);
    drive('hE000, 1, 0, 1, 0, 0);
    drive('hE000, 'h80, 0, 1, 0, 0);
    s_ctrl = s_ctrl | 'h0C;
    idle();
    probe_mir("R1");
    load_reg(1, 'h05);
    probe_prg('h8123, "R1");
    probe_prg('hC456, "R1");
    probe_chr('h0123, 0, "R2");
    probe_mir("R1");
    // R2: four bits alone commit nothing
    for (int i = 0; i < 4; i++) drive('h8000, 1, 0, 1, 0, 0);
    idle();
    probe_mir("R2");
    drive('h8000, 'h80, 0, 1, 0, 0);
    s_ctrl = s_ctrl | 'h0C;
    idle();

    // R10: CPU windows
    drive('h6123, 0, 1, 0, 0, 0);
    push(7, 1, "R10"); push(8, 0, "R10"); push(9, 0, "R10"); push(10, 0, "R10");
    push(11, 'h0123, "R10");
    drive('h7FFF, 'h55, 0, 1, 0, 0);
    push(7, 1, "R10"); push(8, 1, "R10"); push(11, 'h1FFF, "R10");
    drive('h4016, 0, 1, 0, 0, 0);
    push(7, 0, "R10"); push(10, 1, "R10"); push(9, 0, "R10");
    drive('h5FFF, 0, 0, 0, 0, 0);
    push(10, 0, "R10"); push(7, 0, "R10");

    // R11: character writes
    probe_chr('h0800, 1, "R11");
    probe_chr('h1FFF, 1, "R11");
    probe_chr('h2400, 1, "R11");
    probe_chr('h3F00, 1, "R11");
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule